// File: doc/BRIEF.md
# Block Register Load Sequencer

This block carries out a multi-word load into a sixteen-entry, 32-bit register file. A one-cycle start pulse captures a base entry index, a sixteen-bit selection mask and a writeback enable. The sequencer then fetches one word from memory for each selected entry. It uses a single-request, single-response handshake with one read in flight at a time. Each returned word is placed into its entry.

The last entry of the file stands for the program counter. A word fetched for that entry is not stored. It is presented on a branch-target output with a one-cycle valid strobe. Once every read has returned, the base entry may be replaced by the address just past the last word fetched. If the base entry was itself one of the loaded entries, no replacement is made and a conflict flag is raised instead.

A host port writes and reads the register file while the sequencer is idle. It is used to set up base values and to observe the results.

Top module: `lmseq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `mem_req`, `br_valid`, `empty_err` and `base_conflict` are all 0.
- R2: The first read address equals the content of the base entry at the start pulse. Every following read uses the previous read address plus 4. Exactly one read is issued for each set mask bit.
- R3: Selected entries are served from lowest index to highest. The k-th returned word is written into the entry with the k-th lowest set mask bit, for indices 0 to 14.
- R4: When mask bit 15 is set, the final returned word appears on `br_target` with `br_valid` high for exactly one cycle, and entry 15 keeps its content.
- R5: When writeback is on and mask bit `base_idx` is clear, the base entry ends as its start value plus 4 times the number of set mask bits.
- R6: When writeback is off, the base entry holds the loaded word if it is selected, and otherwise its start value.
- R7: When writeback is on and mask bit `base_idx` is set, `base_conflict` is high together with `done`, and the base entry holds the word loaded into it.
- R8: An all-zero mask issues no read, leaves the register file unchanged, and gives `done` with `empty_err` high in the first cycle after the start edge.
- R9: At most one read is in flight. `mem_req` is a one-cycle pulse and is not raised again until `mem_rvalid` has been seen.
- R10: With a memory that answers L cycles after each request, `done` is seen N*(L+1)+2 cycles after the start edge for N set bits. The time depends only on the mask and that latency, never on the data. `done` lasts one cycle, with `busy` low.
- R11: The host port write takes effect when `busy` is low. Host writes and start pulses made while `busy` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| base_idx | input | 4 | Base entry index |
| reg_mask | input | 16 | Entries to load, bit i selects entry i |
| wback | input | 1 | Base update enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| empty_err | output | 1 | Empty mask, valid with done |
| base_conflict | output | 1 | Base was in mask with writeback, valid with done |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| br_valid | output | 1 | Branch target strobe |
| br_target | output | 32 | Loaded program counter value |
| host_we | input | 1 | Host write enable |
| host_widx | input | 4 | Host write index |
| host_wdata | input | 32 | Host write data |
| host_ridx | input | 4 | Host read index |
| host_rdata | output | 32 | Host read data |

## Verification
The hardest case to reach from the ports is a host write or a second start pulse that lands while a sequence is still running. If either leaked through, the effect would only show later as a corrupted entry or extra reads. The stimulus injects both in the second and third cycles of a sequence, aimed at an entry outside the mask. It then reads the whole file back and holds a queue of expected addresses against every request. Memory latency is varied from one to three cycles across random masks. This shows that completion time follows the mask alone, including the base-in-mask case and the mask that holds only the program counter.

// File: rtl/lmseq_pkg.sv
package lmseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_WB,
    ST_FIN
  } seq_st_e;

  function automatic logic [7:0] count_ones(input logic [31:0] v);
    logic [7:0] n;
    n = '0;
    for (int i = 0; i < 32; i++) n = n + 8'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/lmseq_prio.sv
module lmseq_prio #(
  parameter int W = 16,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);

  logic [W:0]   seen;
  logic [W-1:0] first;

  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_chain
      assign first[g]  = vec[g] & ~seen[g];
      assign seen[g+1] = seen[g] | vec[g];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (first[i]) idx = idx | IW'(i);
    end
  end

endmodule

// File: rtl/lmseq_regfile.sv
module lmseq_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic [DW-1:0] rb_data
);

  logic [DW-1:0] ent_q [NREG];

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_ent
      logic ld_en;
      assign ld_en = we && (widx == IW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ent_q[g] <= '0;
        end else if (ld_en) begin
          ent_q[g] <= wdata;
        end
      end
    end
  endgenerate

  assign ra_data = ent_q[ra_idx];
  assign rb_data = ent_q[rb_idx];

endmodule

// File: rtl/lmseq_ctrl.sv
module lmseq_ctrl
  import lmseq_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG),
  localparam int STEP = DW / 8,
  localparam int PCI = NREG - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IW-1:0]   base_idx,
  input  logic [NREG-1:0] reg_mask,
  input  logic            wback,
  input  logic [DW-1:0]   base_val,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  output logic            mem_req,
  output logic [DW-1:0]   mem_addr,
  output logic            rf_we,
  output logic [IW-1:0]   rf_widx,
  output logic [DW-1:0]   rf_wdata,
  output logic            br_valid,
  output logic [DW-1:0]   br_target,
  output logic            busy,
  output logic            done,
  output logic            empty_err,
  output logic            base_conflict
);

  seq_st_e         st_q, st_d;
  logic [IW-1:0]   base_q;
  logic [NREG-1:0] mask_q, rem_q, rem_nxt;
  logic [DW-1:0]   addr_q, orig_q, brt_q;
  logic            wb_q, conf_q, empt_q, brv_q;
  logic            ld_cmd, adv, ld_br;
  logic [IW-1:0]   cur_idx;

  lmseq_prio #(.W(NREG)) i_prio (
    .vec (rem_q),
    .idx (cur_idx)
  );

  assign rem_nxt = rem_q & (rem_q - NREG'(1));

  // next-state and strobes
  always_comb begin
    st_d     = st_q;
    ld_cmd   = 1'b0;
    adv      = 1'b0;
    ld_br    = 1'b0;
    rf_we    = 1'b0;
    rf_widx  = cur_idx;
    rf_wdata = mem_rdata;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          ld_cmd = 1'b1;
          st_d   = (reg_mask == '0) ? ST_FIN : ST_REQ;
        end
      end
      ST_REQ: st_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rvalid) begin
          adv = 1'b1;
          if (cur_idx == IW'(PCI)) ld_br = 1'b1;
          else                     rf_we = 1'b1;
          st_d = (rem_nxt != '0) ? ST_REQ : ST_WB;
        end
      end
      ST_WB: begin
        if (wb_q && !conf_q) begin
          rf_we    = 1'b1;
          rf_widx  = base_q;
          rf_wdata = addr_q;
        end
        st_d = ST_FIN;
      end
      ST_FIN: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      brv_q  <= 1'b0;
      wb_q   <= 1'b0;
      conf_q <= 1'b0;
      empt_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      st_q  <= st_d;
      brv_q <= ld_br;
      if (ld_cmd) begin
        wb_q   <= wback;
        conf_q <= wback & reg_mask[base_idx];
        empt_q <= (reg_mask == '0);
      end
      if (ld_cmd)   rem_q <= reg_mask;
      else if (adv) rem_q <= rem_nxt;
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (ld_cmd) begin
      base_q <= base_idx;
      mask_q <= reg_mask;
      orig_q <= base_val;
    end
    if (ld_cmd)   addr_q <= base_val;
    else if (adv) addr_q <= addr_q + DW'(STEP);
    if (ld_br) brt_q <= mem_rdata;
  end

  assign mem_req       = (st_q == ST_REQ);
  assign mem_addr      = addr_q;
  assign busy          = (st_q == ST_REQ) || (st_q == ST_WAIT) || (st_q == ST_WB);
  assign done          = (st_q == ST_FIN);
  assign empty_err     = done & empt_q;
  assign base_conflict = done & conf_q;
  assign br_valid      = brv_q;
  assign br_target     = brt_q;

  a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  a_r9_no_req_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !mem_rvalid) |=> !mem_req);

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && mem_rvalid) |=> (mem_addr == $past(mem_addr) + DW'(STEP)));

  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && mem_rvalid) |=> ((rem_q == '0) || (cur_idx > $past(cur_idx))));

  a_r4_br_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> !br_valid);

  a_r5_wb_value: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WB && wb_q && !conf_q) |->
      (addr_q == orig_q + DW'(count_ones(32'(mask_q))) * DW'(STEP)));

  a_r8_empty_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start && reg_mask == '0) |=> (!mem_req && done));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/lmseq_top.sv
module lmseq_top #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IW-1:0]   base_idx,
  input  logic [NREG-1:0] reg_mask,
  input  logic            wback,
  output logic            busy,
  output logic            done,
  output logic            empty_err,
  output logic            base_conflict,
  output logic            mem_req,
  output logic [DW-1:0]   mem_addr,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  output logic            br_valid,
  output logic [DW-1:0]   br_target,
  input  logic            host_we,
  input  logic [IW-1:0]   host_widx,
  input  logic [DW-1:0]   host_wdata,
  input  logic [IW-1:0]   host_ridx,
  output logic [DW-1:0]   host_rdata
);

  logic          seq_we, host_ok, wr_en;
  logic [IW-1:0] seq_widx, wr_idx;
  logic [DW-1:0] seq_wdata, wr_data, base_val;

  lmseq_ctrl #(.DW(DW), .NREG(NREG)) i_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .base_idx      (base_idx),
    .reg_mask      (reg_mask),
    .wback         (wback),
    .base_val      (base_val),
    .mem_rvalid    (mem_rvalid),
    .mem_rdata     (mem_rdata),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .rf_we         (seq_we),
    .rf_widx       (seq_widx),
    .rf_wdata      (seq_wdata),
    .br_valid      (br_valid),
    .br_target     (br_target),
    .busy          (busy),
    .done          (done),
    .empty_err     (empty_err),
    .base_conflict (base_conflict)
  );

  // host writes only land while the sequencer is idle
  assign host_ok = host_we & ~busy;
  assign wr_en   = seq_we | host_ok;
  assign wr_idx  = seq_we ? seq_widx  : host_widx;
  assign wr_data = seq_we ? seq_wdata : host_wdata;

  lmseq_regfile #(.DW(DW), .NREG(NREG)) i_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_en),
    .widx    (wr_idx),
    .wdata   (wr_data),
    .ra_idx  (base_idx),
    .ra_data (base_val),
    .rb_idx  (host_ridx),
    .rb_data (host_rdata)
  );

  a_r11_seq_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    seq_we |-> busy);

  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    empty_err |-> done);

  a_r7_conflict_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    base_conflict |-> (done && !empty_err));

endmodule

// File: tb/test_lmseq_top.sv
module test_lmseq_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  base_idx = '0;
  logic [15:0] reg_mask = '0;
  logic        wback = 1'b0;
  logic        busy, done, empty_err, base_conflict, mem_req, br_valid;
  logic [31:0] mem_addr, br_target, host_rdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        host_we = 1'b0;
  logic [3:0]  host_widx = '0;
  logic [31:0] host_wdata = '0;
  logic [3:0]  host_ridx = '0;

  always #2 clk = ~clk;

  lmseq_top i_lmseq_top (
    .clk(clk), .rst_n(rst_n), .start(start), .base_idx(base_idx),
    .reg_mask(reg_mask), .wback(wback), .busy(busy), .done(done),
    .empty_err(empty_err), .base_conflict(base_conflict),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .br_valid(br_valid), .br_target(br_target),
    .host_we(host_we), .host_widx(host_widx), .host_wdata(host_wdata),
    .host_ridx(host_ridx), .host_rdata(host_rdata)
  );

  int          nchk = 0;
  int          nfail = 0;
  int          lat = 1;
  int          cnt = 0;
  int          br_cnt = 0;
  logic [31:0] br_val;
  logic [31:0] salt = 32'h1234_5678;
  logic [31:0] pend_a;
  logic [31:0] mon_a;
  logic [31:0] exp_rf [16];
  logic [31:0] addr_q [$];

  function automatic logic [31:0] mdata(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ salt;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: answers lat cycles after each request
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (cnt != 0) begin
      if (cnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mdata(pend_a);
      end
      cnt <= cnt - 1;
    end
    if (mem_req) begin
      pend_a <= mem_addr;
      if (lat == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mdata(mem_addr);
      end else begin
        cnt <= lat - 1;
      end
    end
  end

  // per-cycle comparison against the expected request stream
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) begin
        if (addr_q.size() == 0) begin
          check(1'b0, "R9 R11 unexpected read", mem_addr, 32'h0);
        end else begin
          mon_a = addr_q.pop_front();
          check(mem_addr == mon_a, "R2 R3 read address", mem_addr, mon_a);
        end
      end
      if (br_valid) begin
        br_cnt++;
        br_val = br_target;
      end
    end
  end

  task automatic host_write(input int i, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_widx = 4'(i); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    exp_rf[i] = d;
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 16; i++) begin
      host_ridx = 4'(i);
      #1;
      check(host_rdata == exp_rf[i], tag, host_rdata, exp_rf[i]);
    end
  endtask

  task automatic run_op(input int b, input logic [15:0] m, input bit w, input int l, input bit poke);
    logic [31:0] a0, a, exp_br;
    int n, cyc, exp_cyc, pidx;
    bit conf;
    lat = l;
    salt = $urandom;
    a0 = exp_rf[b];
    a = a0;
    n = 0;
    br_cnt = 0;
    exp_br = '0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        addr_q.push_back(a);
        if (i == 15) exp_br = mdata(a);
        else         exp_rf[i] = mdata(a);
        a = a + 32'd4;
        n++;
      end
    end
    conf = w && m[b];
    if (w && !m[b]) exp_rf[b] = a0 + 32'(4 * n);
    exp_cyc = (n == 0) ? 1 : n * (l + 1) + 2;
    pidx = -1;
    for (int i = 0; i < 15; i++) begin
      if (!m[i] && i != b && pidx < 0) pidx = i;
    end
    @(negedge clk);
    start = 1'b1; base_idx = 4'(b); reg_mask = m; wback = w;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 2000) begin
      if (poke && n > 0 && cyc == 2) begin
        start = 1'b1; reg_mask = 16'h0001; base_idx = 4'(b);
        if (pidx >= 0) begin
          host_we = 1'b1; host_widx = 4'(pidx); host_wdata = ~exp_rf[pidx];
        end
      end
      if (cyc == 3) begin
        start = 1'b0; host_we = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; host_we = 1'b0;
    check(cyc == exp_cyc, "R10 done timing", 32'(cyc), 32'(exp_cyc));
    check(empty_err == (m == 16'h0), "R8 empty flag", 32'(empty_err), 32'(m == 16'h0));
    check(base_conflict == conf, "R7 conflict flag", 32'(base_conflict), 32'(conf));
    check(!busy, "R10 busy low at done", 32'(busy), 32'h0);
    check(addr_q.size() == 0, "R2 read count", 32'(addr_q.size()), 32'h0);
    addr_q.delete();
    check(br_cnt == int'(m[15]), "R4 branch strobe count", 32'(br_cnt), 32'(m[15]));
    if (m[15]) check(br_val == exp_br, "R4 branch target", br_val, exp_br);
    @(negedge clk);
    check(!done, "R10 done single cycle", 32'(done), 32'h0);
    read_all("R3 R5 R6 R7 R11 entry contents");
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #1;
    check(!busy && !done && !mem_req && !br_valid && !empty_err && !base_conflict,
          "R1 outputs in reset", 32'({busy, done, mem_req, br_valid}), 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mem_req && !br_valid && !empty_err && !base_conflict,
          "R1 outputs after reset", 32'({busy, done, mem_req, br_valid}), 32'h0);
    for (int i = 0; i < 16; i++) exp_rf[i] = '0;
    read_all("R1 entries cleared");
    for (int i = 0; i < 16; i++) host_write(i, 32'h1000 * (i + 1) + $urandom % 16 * 4);
    read_all("R11 idle host write");

    run_op(3, 16'h00F0, 1'b1, 1, 1'b1);   // R5 base outside mask
    run_op(3, 16'h0000, 1'b1, 1, 1'b0);   // R8 empty mask
    run_op(2, 16'h8005, 1'b0, 2, 1'b1);   // R4 R6 branch, no writeback
    run_op(4, 16'h0014, 1'b1, 3, 1'b0);   // R7 base inside mask
    run_op(0, 16'hFFFE, 1'b1, 1, 1'b1);   // R5 long list
    run_op(5, 16'h8000, 1'b1, 2, 1'b0);   // R4 only program counter
    run_op(6, 16'h0040, 1'b0, 3, 1'b1);   // R6 single base load
    for (int k = 0; k < 24; k++) begin
      run_op(int'($urandom % 16), 16'($urandom), 1'($urandom), 1 + int'($urandom % 3), 1'b1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule